// File: doc/BRIEF.md
# SIMD Lane-Wise Absolute / Negate Unit

This block is one execution slice of a 128-bit SIMD register datapath. It takes a 32-bit operation word, reads the source vector from a built-in 32 x 128-bit register file, and computes a signed absolute value or a two's-complement negation independently in every lane. Lanes are 8, 16, 32 or 64 bits wide. The active width is 64 bits (narrow vector), 128 bits (full vector) or a single lane (scalar).

The result register is assembled from zero and written back as a complete 128-bit value. Narrow and scalar shapes therefore never merge with what the destination held before. Every bit above the active width is written as zero, and source bits above the active width have no effect. The write-back happens one cycle after the operation strobe. A load port fills registers, and a peek port reads them back, which lets the surrounding datapath or a bench prepare and inspect the file.

A 64-bit lane with the narrow width describes a single lane that is smaller than a full register but is not a scalar. That shape is rejected: the block raises a one-cycle flag and suppresses the write.

Top module: `simd_absneg_unit`

## Requirements
- R1: With op-word bit 29 clear, each lane result is the absolute value of the lane read as a signed integer.
- R2: With op-word bit 29 set, each lane result is the two's-complement negation of the lane.
- R3: Each lane result keeps only its low lane-width bits, so the most negative value of every lane size comes back unchanged under both operations.
- R4: With bit 30 clear (narrow vector), only the low 64 source bits are used and result bits 127:64 are zero.
- R5: With bit 30 set (full vector) and bit 28 clear, all 128 bits are processed, as 128 / lane-width lanes.
- R6: With bit 28 set (scalar), only lane 0 is processed and every result bit above the lane width is zero, whatever bit 30 holds.
- R7: The previous contents of the destination register never appear in the written value.
- R8: Lane size code 3 (64-bit) with bit 30 clear and bit 28 clear raises `shape_err` for one cycle one clock after the strobe, asserts no write, and leaves the register file unchanged.
- R9: `wb_en`, `wb_idx` and `wb_data` are valid in the cycle after the `op_valid` strobe, and the written value can be read on the peek port from the cycle after that.
- R10: Op-word fields: destination index bits 4:0, source index bits 9:5, lane size bits 23:22 (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits), width bit 30, negate bit 29, scalar bit 28.
- R11: Synchronous active-high reset clears `wb_en`, `shape_err` and every register of the file.
- R12: A `ld_en` pulse writes `ld_data` to register `ld_idx`, readable on the peek port the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe, one cycle per op |
| op_word | input | 32 | Operation word (fields per R10) |
| ld_en | input | 1 | Register-file load strobe |
| ld_idx | input | 5 | Register index to load |
| ld_data | input | 128 | Value to load |
| peek_idx | input | 5 | Register index to read back when no op is issued |
| peek_data | output | 128 | Contents of the register selected on the shared read port |
| wb_en | output | 1 | Write-back strobe |
| wb_idx | output | 5 | Write-back destination index |
| wb_data | output | 128 | Write-back value |
| shape_err | output | 1 | Illegal-shape pulse (R8) |

## Verification
The hardest situation to show from the ports is that a narrow or scalar write does not merge with the old destination. A zero-initialised register would make a correct and a merging design look the same. The stimulus therefore loads all ones into each destination through the load port before every operation. It also places non-zero data in the upper source half, and then checks both the write-back bus and a later peek of the register. Most-negative lane values are built for every lane size, so that the wrap of R3 is reached in each size.

// File: rtl/simd_absneg_pkg.sv
package simd_absneg_pkg;

    localparam int VLEN   = 128;
    localparam int HALF   = VLEN / 2;
    localparam int NREGS  = 32;
    localparam int IDX_W  = $clog2(NREGS);
    localparam int NSIZES = 4;

    typedef enum logic [1:0] {
        ESZ_8  = 2'd0,
        ESZ_16 = 2'd1,
        ESZ_32 = 2'd2,
        ESZ_64 = 2'd3
    } esz_e;

    typedef struct packed {
        logic [IDX_W-1:0] dst;
        logic [IDX_W-1:0] src;
        esz_e             esz;
        logic             full;
        logic             neg;
        logic             scalar;
        logic             legal;
    } op_t;

    function automatic int unsigned lane_bits(esz_e e);
        return 32'd8 << e;
    endfunction

    // Bits that survive into the written register; all others become zero.
    function automatic logic [VLEN-1:0] keep_mask(op_t op);
        int unsigned active;
        if (op.scalar)    active = lane_bits(op.esz);
        else if (op.full) active = VLEN;
        else              active = HALF;
        if (active >= VLEN) return '1;
        return ({{(VLEN-1){1'b0}}, 1'b1} << active) - {{(VLEN-1){1'b0}}, 1'b1};
    endfunction

endpackage

// File: rtl/simd_decode.sv
module simd_decode
    import simd_absneg_pkg::*;
(
    input  logic [31:0] word,
    output op_t         op
);
    logic unused_bits;
    assign unused_bits = ^{word[31], word[27:24], word[21:10]};

    always_comb begin
        op.dst    = word[4:0];
        op.src    = word[9:5];
        op.esz    = esz_e'(word[23:22]);
        op.full   = word[30];
        op.neg    = word[29];
        op.scalar = word[28];
        op.legal  = !(op.esz == ESZ_64 && !op.full && !op.scalar);
    end
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
    import simd_absneg_pkg::*;
#(
    parameter int W_VEC = VLEN
) (
    input  logic [W_VEC-1:0] src,
    input  esz_e             esz,
    input  logic             neg,
    output logic [W_VEC-1:0] res
);
    logic [NSIZES-1:0][W_VEC-1:0] cand;

    for (genvar gs = 0; gs < NSIZES; gs++) begin : g_size
        localparam int LW = 8 << gs;
        localparam int NL = W_VEC / LW;
        for (genvar gl = 0; gl < NL; gl++) begin : g_lane
            logic [LW-1:0] a;
            assign a = src[gl*LW +: LW];
            // Negating wraps in LW bits, so the minimum maps to itself.
            assign cand[gs][gl*LW +: LW] = (neg || a[LW-1]) ? (~a + 1'b1) : a;
        end
    end

    assign res = cand[esz];

    always_comb begin
        if (!neg && esz == ESZ_8 && src[7:0] != 8'h80)
            assert_abs_nonneg_R1: assert (res[7] == 1'b0);
    end
endmodule

// File: rtl/simd_regfile.sv
module simd_regfile
    import simd_absneg_pkg::*;
#(
    parameter int W_VEC  = VLEN,
    parameter int DEPTH  = NREGS,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_idx,
    input  logic [W_VEC-1:0] wr_data,
    input  logic [AW-1:0]    rd_idx,
    output logic [W_VEC-1:0] rd_data
);
    logic [W_VEC-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

    assert_write_lands_R9: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mem[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/simd_absneg_unit.sv
module simd_absneg_unit
    import simd_absneg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [31:0]       op_word,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [VLEN-1:0]   ld_data,
    input  logic [IDX_W-1:0]  peek_idx,
    output logic [VLEN-1:0]   peek_data,
    output logic              wb_en,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [VLEN-1:0]   wb_data,
    output logic              shape_err
);
    op_t              op;
    logic [IDX_W-1:0] rd_idx;
    logic [VLEN-1:0]  rd_data;
    logic [VLEN-1:0]  alu_res;
    logic [VLEN-1:0]  fresh;
    logic             rf_we;
    logic [IDX_W-1:0] rf_widx;
    logic [VLEN-1:0]  rf_wdata;
    logic             last_narrow;

    simd_decode u_dec (.word(op_word), .op(op));

    // Single read port shared by the operand fetch and the peek path.
    assign rd_idx    = op_valid ? op.src : peek_idx;
    assign peek_data = rd_data;

    simd_lane_alu #(.W_VEC(VLEN)) u_alu (
        .src(rd_data), .esz(op.esz), .neg(op.neg), .res(alu_res)
    );

    // Built from zero: the old destination value is never an input.
    assign fresh = alu_res & keep_mask(op);

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_en       <= 1'b0;
            shape_err   <= 1'b0;
            wb_idx      <= '0;
            wb_data     <= '0;
            last_narrow <= 1'b0;
        end else begin
            wb_en       <= op_valid && op.legal;
            shape_err   <= op_valid && !op.legal;
            last_narrow <= op_valid && (!op.full || op.scalar);
            if (op_valid && op.legal) begin
                wb_idx  <= op.dst;
                wb_data <= fresh;
            end
        end
    end

    assign rf_we    = wb_en || ld_en;
    assign rf_widx  = wb_en ? wb_idx  : ld_idx;
    assign rf_wdata = wb_en ? wb_data : ld_data;

    simd_regfile #(.W_VEC(VLEN), .DEPTH(NREGS)) u_rf (
        .clk(clk), .rst(rst),
        .wr_en(rf_we), .wr_idx(rf_widx), .wr_data(rf_wdata),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    assert_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (wb_en && last_narrow) |-> wb_data[VLEN-1:HALF] == '0);

    assert_wb_after_valid_R9: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> $past(op_valid));

    assert_no_write_on_err_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wb_en, shape_err}));

    assert_err_cause_R8: assert property (@(posedge clk) disable iff (rst)
        shape_err |-> ($past(op_word[23:22]) == 2'd3 && !$past(op_word[30])));

    assert_dst_field_R10: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> wb_idx == $past(op_word[4:0]));
endmodule

// File: tb/simd_absneg_unit_tb.sv
module simd_absneg_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         op_valid;
    logic [31:0]  op_word;
    logic         ld_en;
    logic [4:0]   ld_idx;
    logic [127:0] ld_data;
    logic [4:0]   peek_idx;
    logic [127:0] peek_data;
    logic         wb_en;
    logic [4:0]   wb_idx;
    logic [127:0] wb_data;
    logic         shape_err;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_absneg_unit u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_word(op_word),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .peek_idx(peek_idx), .peek_data(peek_data),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .shape_err(shape_err)
    );

    typedef struct packed {
        logic [1:0]   sz;
        logic         full;
        logic         neg;
        logic         scl;
        logic [4:0]   s;
        logic [4:0]   d;
        logic [127:0] val;
    } vec_t;

    localparam logic [127:0] P1 = 128'hDEAD_BEEF_8000_0001_7FFF_FFFF_8080_FF01;
    localparam logic [127:0] P2 = 128'h8000_7FFF_0001_FFFF_1234_EDCC_0000_8001;
    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 1'b0, 1'b0, 5'd13, 5'd31, P1},
        '{2'd0, 1'b1, 1'b1, 1'b0, 5'd2,  5'd5,  P1},
        '{2'd1, 1'b0, 1'b0, 1'b0, 5'd7,  5'd7,  P1},
        '{2'd1, 1'b1, 1'b1, 1'b0, 5'd13, 5'd31, P2},
        '{2'd2, 1'b0, 1'b1, 1'b0, 5'd20, 5'd1,  P2},
        '{2'd2, 1'b1, 1'b0, 1'b0, 5'd13, 5'd31, P1},
        '{2'd3, 1'b1, 1'b0, 1'b0, 5'd3,  5'd30, P1},
        '{2'd3, 1'b1, 1'b1, 1'b0, 5'd13, 5'd31, P2},
        '{2'd0, 1'b1, 1'b1, 1'b1, 5'd13, 5'd31, P1},
        '{2'd3, 1'b0, 1'b0, 1'b1, 5'd9,  5'd10, P2},
        '{2'd1, 1'b1, 1'b0, 1'b1, 5'd13, 5'd31, P1}
    };

    function automatic logic [127:0] model(logic [1:0] sz, logic full, logic neg,
                                           logic scl, logic [127:0] s);
        int w  = 8 << sz;
        int nl = scl ? 1 : ((full ? 128 : 64) / w);
        logic [127:0] r = '0;
        for (int e = 0; e < nl; e++) begin
            logic [63:0] m;
            logic [63:0] raw;
            logic signed [63:0] sv;
            logic [63:0] o;
            m   = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
            raw = 64'(s >> (e * w)) & m;
            sv  = raw[w-1] ? (raw | ~m) : raw;
            if (neg) o = -sv;
            else     o = (sv < 0) ? -sv : sv;
            r = r | (128'(o & m) << (e * w));
        end
        return r;
    endfunction

    function automatic logic [31:0] mk(logic [1:0] sz, logic full, logic neg,
                                       logic scl, logic [4:0] s, logic [4:0] d);
        logic [31:0] w = '0;
        w[4:0] = d; w[9:5] = s; w[23:22] = sz;
        w[30] = full; w[29] = neg; w[28] = scl;
        return w;
    endfunction

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load(logic [4:0] idx, logic [127:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = idx; ld_data = v;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Issue op, check write-back bus next cycle, then peek the destination.
    task automatic run_op(string req, logic [31:0] w, logic [127:0] exp);
        @(negedge clk);
        op_valid = 1'b1; op_word = w;
        @(negedge clk);
        op_valid = 1'b0;
        peek_idx = w[4:0];
        chk({req, " R9 wb_en"}, 128'(wb_en), 128'd1);
        chk({req, " R10 wb_idx"}, 128'(wb_idx), 128'(w[4:0]));
        chk({req, " wb_data"}, wb_data, exp);
        @(negedge clk);
        chk({req, " R7 peek dst"}, peek_data, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; op_valid = 1'b0; op_word = '0;
        ld_en = 1'b0; ld_idx = '0; ld_data = '0; peek_idx = 5'd31;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        chk("R11 wb_en", 128'(wb_en), 128'd0);
        chk("R11 shape_err", 128'(shape_err), 128'd0);
        chk("R11 reg31 cleared", peek_data, 128'd0);

        // R12: load port
        load(5'd4, P2);
        peek_idx = 5'd4;
        #1 chk("R12 load readback", peek_data, P2);

        // Table walk: R1 R2 R4 R5 R6 R7 R10, destination preloaded with ones
        for (int i = 0; i < NV; i++) begin
            vec_t v = VECS[i];
            load(v.s, v.val);
            if (v.d != v.s) load(v.d, '1);
            run_op($sformatf("R1/R2/R4/R5/R6 vec%0d", i),
                   mk(v.sz, v.full, v.neg, v.scl, v.s, v.d),
                   model(v.sz, v.full, v.neg, v.scl, v.val));
        end

        // R1 R4: two 32-bit lanes, abs, reg 13 into reg 31, hand-computed
        load(5'd13, {64'h1111_2222_3333_4444, 32'hFFFF_FFFF, 32'h8000_0000});
        load(5'd31, '1);
        run_op("R4 2x32 abs example", mk(2'd2, 1'b0, 1'b0, 1'b0, 5'd13, 5'd31),
               {64'd0, 32'h0000_0001, 32'h8000_0000});

        // R3: minimum value wraps in every lane size, both operations
        load(5'd13, {16{8'h80}});
        load(5'd31, '1);
        run_op("R3 min 8b abs", mk(2'd0, 1'b0, 1'b0, 1'b0, 5'd13, 5'd31), {64'd0, {8{8'h80}}});
        load(5'd13, {8{16'h8000}});
        load(5'd31, '1);
        run_op("R3 min 16b neg", mk(2'd1, 1'b0, 1'b1, 1'b0, 5'd13, 5'd31), {64'd0, {4{16'h8000}}});
        load(5'd13, {4{32'h8000_0000}});
        load(5'd31, '1);
        run_op("R3 min 32b abs", mk(2'd2, 1'b0, 1'b0, 1'b0, 5'd13, 5'd31), {64'd0, {2{32'h8000_0000}}});
        load(5'd13, {2{64'h8000_0000_0000_0000}});
        load(5'd31, '1);
        run_op("R3 min 64b neg", mk(2'd3, 1'b1, 1'b1, 1'b0, 5'd13, 5'd31), {2{64'h8000_0000_0000_0000}});

        // R8: 64-bit lane with narrow width is rejected, destination untouched
        load(5'd31, '1);
        @(negedge clk);
        op_valid = 1'b1; op_word = mk(2'd3, 1'b0, 1'b0, 1'b0, 5'd13, 5'd31);
        @(negedge clk);
        op_valid = 1'b0; peek_idx = 5'd31;
        chk("R8 shape_err", 128'(shape_err), 128'd1);
        chk("R8 no wb_en", 128'(wb_en), 128'd0);
        @(negedge clk);
        chk("R8 shape_err one cycle", 128'(shape_err), 128'd0);
        chk("R8 dst unchanged", peek_data, '1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule